// File: doc/BRIEF.md
# Staged Multi-Word Memory Copier

This block copies a run of words from one memory region to another in two steps, using a staging buffer. A load command fetches words from consecutive addresses into the buffer. A later store command writes words from the buffer to consecutive addresses at a destination. The load and store counts are independent. If the load count is larger than the store count, the excess earliest words are dropped. If it is smaller, the missing words come from words left over from the previous load. Words always reach the destination in the order they were fetched.

There are two independent staging buffers. The single-word buffer holds up to `WORD_MAX` words, and its count digit gives the number of words directly. The grouped buffer holds up to `GRP_MAX` groups of `GRP_SIZE` words, and its count digit gives a number of groups. A count digit outside the legal range turns the command into a skip. The block accepts a command only while idle. It drives a single-port synchronous memory that has one cycle of read latency, and it signals completion with a one-cycle done pulse.

Top module: `blk_stage_xfer`

## Requirements
- R1: After reset, busy, done and mem_req are low, and both buffers hold only zero words. A store issued straight after reset writes zeros.
- R2: A non-skip command of length N makes exactly N memory accesses, one per cycle, at addresses base, base+1, …, base+N−1. A load makes reads only and a store makes writes only.
- R3: In single-word mode (cmd_op bit 1 = 0), count digits 1..9 give 1..9 words. Digit 0 and digits 10..15 make the command a skip: no memory access, no buffer change, busy stays low, and done pulses in the cycle after acceptance.
- R4: With equal load and store counts, the store writes the loaded words in fetch order. This includes a two-word transfer.
- R5: If the load count n1 is greater than the store count n2, the store writes only the last n2 loaded words. The first n1−n2 are never written.
- R6: If n1 is less than n2, the store first writes the n2−n1 newest words left over from the previous load, then the n1 words of the current load. Buffer contents persist between commands, so repeating a store writes the same words again.
- R7: In grouped mode (cmd_op bit 1 = 1), digits 1..6 give 10..60 words in a separate buffer. Grouped commands leave the single-word buffer untouched.
- R8: In grouped mode, digit 0 and digits 7..15 make the command a skip, with the same behaviour as R3.
- R9: Busy rises in the cycle after acceptance. It stays high for N+1 cycles for a load and N cycles for a store. Done is high for exactly one cycle, and that cycle is the first cycle in which busy is low again.
- R10: While busy is high, cmd_valid is ignored: no extra access occurs and the buffers are unaffected.
- R11: cmd_op bit 0 selects the direction: 0 loads (memory to buffer), 1 stores (buffer to memory).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 2 | Bit 1: grouped mode; bit 0: store (1) or load (0) |
| cmd_count | input | 4 | Count digit |
| cmd_addr | input | ADDR_W | Base address of the run |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read request |

## Verification
The bench keeps the default buffer shape (nine single words, six groups of ten) and narrows ADDR_W to 8, so that a 256-word memory model holds every source and destination region. At full size, both the deepest single-word transfer and a 60-word grouped transfer can be exercised. Digits just past each mode's limit (10, 12, 7) can be issued to probe the skip boundary. Unequal load/store pairs in both directions show which words are dropped and which are reused.

// File: rtl/stx_pkg.sv
// Package: shared state encoding and opcode bit positions for the staged copier.
package stx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_WRITE = 2'd3
    } xfer_state_t;

    localparam int OP_STORE_BIT = 0;
    localparam int OP_GROUP_BIT = 1;
endpackage

// File: rtl/stx_stage_buf.sv
// stx_stage_buf: shift-register staging store.
// A push puts the new word at index 0 and moves every older word up by one.
// Index 0 is always the newest word. Reads are combinational, and an index
// beyond DEPTH returns zero. Contents change only on push or reset.
module stx_stage_buf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 9,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] ent [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            if (gi == 0) begin : g_head
                // Purpose: load the newest word into the head slot.
                always_ff @(posedge clk) begin
                    if (!rst_n)    ent[0] <= '0;
                    else if (push) ent[0] <= push_data;
                end
            end else begin : g_body
                // Purpose: age each slot by one on every push.
                always_ff @(posedge clk) begin
                    if (!rst_n)    ent[gi] <= '0;
                    else if (push) ent[gi] <= ent[gi-1];
                end
            end
        end
    endgenerate

    // Purpose: select the addressed slot for the store path.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = ent[k];
        end
    end
endmodule

// File: rtl/stx_ctrl.sv
// stx_ctrl: command decode and sequencing for the staged copier.
// Takes a command only in idle and turns the count digit into a word length.
// Loads issue one read per cycle and then wait one drain cycle for the last
// read data; each returning word is pushed one cycle after its request.
// Stores issue one write per cycle, taking the oldest of the selected words
// first. Assumes memory read data arrives one cycle after the request.
module stx_ctrl
    import stx_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 6,
    parameter int WORD_MAX = 9,
    parameter int GRP_SIZE = 10,
    parameter int GRP_MAX  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [3:0]        cmd_count,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              push,
    output logic              grp_sel,
    output logic [CNT_W-1:0]  rd_idx
);
    localparam logic [3:0]       WMAX_D = 4'(WORD_MAX);
    localparam logic [3:0]       GMAX_D = 4'(GRP_MAX);
    localparam logic [CNT_W-1:0] GSZ    = CNT_W'(GRP_SIZE);

    xfer_state_t       state_q;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;
    logic              grp_q;
    logic              pend_q;
    logic              done_q;
    logic [CNT_W-1:0]  req_len;
    logic              last_beat;
    logic              accept;

    // Purpose: turn the count digit into a word length; zero means skip.
    always_comb begin
        req_len = '0;
        if (cmd_op[OP_GROUP_BIT]) begin
            if (cmd_count != 4'd0 && cmd_count <= GMAX_D)
                req_len = CNT_W'(cmd_count) * GSZ;
        end else begin
            if (cmd_count != 4'd0 && cmd_count <= WMAX_D)
                req_len = CNT_W'(cmd_count);
        end
    end

    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign last_beat = (idx_q == len_q - CNT_W'(1));

    // Purpose: sequence the states, counters and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            idx_q   <= '0;
            base_q  <= '0;
            grp_q   <= 1'b0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            pend_q <= (state_q == ST_READ);
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (req_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            len_q   <= req_len;
                            idx_q   <= '0;
                            base_q  <= cmd_addr;
                            grp_q   <= cmd_op[OP_GROUP_BIT];
                            state_q <= cmd_op[OP_STORE_BIT] ? ST_WRITE : ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    idx_q <= idx_q + CNT_W'(1);
                    if (last_beat) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                ST_WRITE: begin
                    idx_q <= idx_q + CNT_W'(1);
                    if (last_beat) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive the memory port and the buffer controls from the state.
    always_comb begin
        mem_req  = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we   = (state_q == ST_WRITE);
        mem_addr = base_q + ADDR_W'(idx_q);
        rd_idx   = len_q - CNT_W'(1) - idx_q;
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign push    = pend_q;
    assign grp_sel = grp_q;
endmodule

// File: rtl/blk_stage_xfer.sv
// blk_stage_xfer: top of the staged multi-word copier.
// Holds one single-word staging buffer and one grouped staging buffer. The
// controller chooses between them per command. Read data is pushed into the
// buffer chosen by the current command, and store data is taken from the same
// buffer. Assumes ADDR_W is at least the width of the length counter.
module blk_stage_xfer #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 16,
    parameter int WORD_MAX = 9,
    parameter int GRP_SIZE = 10,
    parameter int GRP_MAX  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [3:0]        cmd_count,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int GRP_DEPTH = GRP_SIZE * GRP_MAX;
    localparam int BIG_DEPTH = (GRP_DEPTH > WORD_MAX) ? GRP_DEPTH : WORD_MAX;
    localparam int CNT_W     = $clog2(BIG_DEPTH + 1);

    logic              push;
    logic              grp_sel;
    logic [CNT_W-1:0]  rd_idx;
    logic [DATA_W-1:0] word_rd;
    logic [DATA_W-1:0] grp_rd;

    stx_ctrl #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_MAX(WORD_MAX),
        .GRP_SIZE(GRP_SIZE), .GRP_MAX(GRP_MAX)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_count(cmd_count),
        .cmd_addr(cmd_addr), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .push(push), .grp_sel(grp_sel), .rd_idx(rd_idx)
    );

    stx_stage_buf #(.DATA_W(DATA_W), .DEPTH(WORD_MAX), .IDX_W(CNT_W)) u_word_buf (
        .clk(clk), .rst_n(rst_n), .push(push && !grp_sel),
        .push_data(mem_rdata), .rd_idx(rd_idx), .rd_data(word_rd)
    );

    stx_stage_buf #(.DATA_W(DATA_W), .DEPTH(GRP_DEPTH), .IDX_W(CNT_W)) u_grp_buf (
        .clk(clk), .rst_n(rst_n), .push(push && grp_sel),
        .push_data(mem_rdata), .rd_idx(rd_idx), .rd_data(grp_rd)
    );

    // Purpose: route write data from the buffer that the command selected.
    assign mem_wdata = grp_sel ? grp_rd : word_rd;
endmodule

// File: rtl/stx_checker.sv
// stx_checker: port-level properties of blk_stage_xfer, attached by bind.
module stx_checker #(
    parameter int ADDR_W   = 16,
    parameter int WORD_MAX = 9,
    parameter int GRP_MAX  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [3:0]        cmd_count,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr
);
    logic skip_cmd;
    assign skip_cmd = cmd_valid && !busy &&
        (cmd_count == 4'd0 ||
         (!cmd_op[1] && cmd_count > 4'(WORD_MAX)) ||
         ( cmd_op[1] && cmd_count > 4'(GRP_MAX)));

    // R2: back-to-back accesses walk consecutive addresses
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

    // R3, R8: a skip never goes busy and completes on the next cycle
    a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        skip_cmd |=> done && !busy && !mem_req);

    // R9: memory is touched only while busy
    a_r9_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R9: done never overlaps busy
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: the end of every busy window raises done
    a_r9_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind blk_stage_xfer stx_checker #(
    .ADDR_W(ADDR_W), .WORD_MAX(WORD_MAX), .GRP_MAX(GRP_MAX)
) u_stx_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_count(cmd_count), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_addr(mem_addr)
);

// File: tb/blk_stage_xfer_tb_top.sv
// Directed bench for blk_stage_xfer with a one-cycle-latency memory model.
module blk_stage_xfer_tb_top;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [3:0]    cmd_count = 4'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic          busy, done, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    bit finished = 1'b0;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] wmod [9];
    logic [DW-1:0] gmod [60];

    always #2.5 clk = ~clk;

    blk_stage_xfer #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .cmd_addr(cmd_addr), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: synchronous, read data one cycle after the request.
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_req && !mem_we) begin
            mem_rdata <= mem[mem_addr];
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one command and wait for done; return the busy cycle count.
    task automatic run_cmd(input logic [1:0] op, input logic [3:0] cnt,
                           input int addr, output int bcyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_count = cnt; cmd_addr = AW'(addr);
        @(negedge clk);
        cmd_valid = 1'b0;
        bcyc = 0;
        for (int g = 0; g < 200 && !done; g++) begin
            if (busy) bcyc++;
            @(negedge clk);
        end
    endtask

    function automatic void model_load(input bit grp, input int n, input int src);
        for (int i = 0; i < n; i++) begin
            if (grp) begin
                for (int k = 59; k > 0; k--) gmod[k] = gmod[k-1];
                gmod[0] = mem[src+i];
            end else begin
                for (int k = 8; k > 0; k--) wmod[k] = wmod[k-1];
                wmod[0] = mem[src+i];
            end
        end
    endfunction

    task automatic check_store(input bit grp, input int n, input int dst, input string tag);
        for (int k = 0; k < n; k++) begin
            logic [DW-1:0] e;
            e = grp ? gmod[n-1-k] : wmod[n-1-k];
            check(mem[dst+k] === e, tag, mem[dst+k], e);
        end
    endtask

    task automatic t_reset();
        int b;
        check(!busy && !done && !mem_req, "R1 idle outputs", {busy, done, mem_req}, 0);
        run_cmd(2'b01, 4'd9, 128, b);
        for (int k = 0; k < 9; k++) check(mem[128+k] === 16'h0, "R1 cleared word buffer", mem[128+k], 0);
        run_cmd(2'b11, 4'd1, 140, b);
        for (int k = 0; k < 10; k++) check(mem[140+k] === 16'h0, "R1 cleared group buffer", mem[140+k], 0);
    endtask

    task automatic t_equal_two();
        int b, r0, w0;
        r0 = rd_cnt;
        run_cmd(2'b00, 4'd2, 0, b);
        model_load(0, 2, 0);
        check(b == 3, "R9 load busy length", b, 3);
        check(rd_cnt - r0 == 2, "R2 load read count", rd_cnt - r0, 2);
        w0 = wr_cnt;
        run_cmd(2'b01, 4'd2, 160, b);
        check(b == 2, "R9 store busy length", b, 2);
        check(wr_cnt - w0 == 2, "R2 store write count", wr_cnt - w0, 2);
        check(mem[160] === 16'hA000 && mem[161] === 16'hA001, "R4 R11 two-word order", mem[160], 16'hA000);
        check_store(0, 2, 160, "R4 equal counts");
    endtask

    task automatic t_load_more();
        int b;
        run_cmd(2'b00, 4'd5, 16, b);
        model_load(0, 5, 16);
        run_cmd(2'b01, 4'd3, 165, b);
        check(mem[165] === 16'hA012, "R5 first kept word", mem[165], 16'hA012);
        check(mem[168] === 16'hFFFF, "R5 no extra write", mem[168], 16'hFFFF);
        check_store(0, 3, 165, "R5 drop oldest");
    endtask

    task automatic t_load_less();
        int b;
        run_cmd(2'b00, 4'd4, 32, b);
        model_load(0, 4, 32);
        run_cmd(2'b01, 4'd7, 170, b);
        check(mem[170] === 16'hA012 && mem[173] === 16'hA020, "R6 leftovers then new", mem[173], 16'hA020);
        check_store(0, 7, 170, "R6 reuse leftovers");
        run_cmd(2'b01, 4'd7, 180, b);
        check_store(0, 7, 180, "R6 retained repeat");
    endtask

    task automatic t_word_skip();
        int b, r0, w0;
        r0 = rd_cnt;
        run_cmd(2'b00, 4'd0, 48, b);
        check(b == 0 && rd_cnt == r0, "R3 digit 0 skip", b, 0);
        run_cmd(2'b00, 4'd12, 48, b);
        check(b == 0 && rd_cnt == r0, "R3 digit 12 skip", b, 0);
        w0 = wr_cnt;
        run_cmd(2'b01, 4'd10, 190, b);
        check(b == 0 && wr_cnt == w0, "R3 digit 10 store skip", wr_cnt - w0, 0);
        run_cmd(2'b01, 4'd9, 190, b);
        check_store(0, 9, 190, "R3 buffer unchanged");
    endtask

    task automatic t_group();
        int b, r0;
        r0 = rd_cnt;
        run_cmd(2'b10, 4'd2, 40, b);
        model_load(1, 20, 40);
        check(rd_cnt - r0 == 20, "R7 group read count", rd_cnt - r0, 20);
        check(b == 21, "R9 group load busy", b, 21);
        run_cmd(2'b11, 4'd1, 200, b);
        check(mem[200] === 16'hA032, "R7 group first word", mem[200], 16'hA032);
        check_store(1, 10, 200, "R7 group store");
        run_cmd(2'b01, 4'd9, 210, b);
        check_store(0, 9, 210, "R7 word buffer untouched");
    endtask

    task automatic t_group_skip();
        int b, r0;
        r0 = rd_cnt;
        run_cmd(2'b10, 4'd7, 60, b);
        check(b == 0 && rd_cnt == r0, "R8 digit 7 skip", b, 0);
        run_cmd(2'b10, 4'd0, 60, b);
        check(b == 0 && rd_cnt == r0, "R8 digit 0 skip", b, 0);
        run_cmd(2'b11, 4'd2, 220, b);
        check_store(1, 20, 220, "R8 group buffer unchanged");
    endtask

    task automatic t_busy_ignore();
        int w0, b;
        w0 = wr_cnt;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_count = 4'd9; cmd_addr = AW'(64);
        @(negedge clk);
        cmd_op = 2'b01; cmd_count = 4'd9; cmd_addr = AW'(240);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        for (int g = 0; g < 50 && !done; g++) @(negedge clk);
        model_load(0, 9, 64);
        check(wr_cnt == w0, "R10 no write while busy", wr_cnt - w0, 0);
        run_cmd(2'b01, 4'd9, 240, b);
        check_store(0, 9, 240, "R10 buffer holds load");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? (16'hA000 + 16'(i)) : 16'hFFFF;
        for (int i = 0; i < 9; i++) wmod[i] = '0;
        for (int i = 0; i < 60; i++) gmod[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_equal_two();
        t_load_more();
        t_load_less();
        t_word_skip();
        t_group();
        t_group_skip();
        t_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule